// File: doc/BRIEF.md
# Four-Core Snooping Coherence Fabric

This block connects four cores, each with a small private write-through data cache, to one shared main memory over a single shared bus. Every store goes out to memory. All caches watch the bus so that a store by one core cannot leave another core reading an old copy. A two-bit mode input selects the snooping policy at run time. In invalidate mode, the other cores discard a matching line. In update mode, they overwrite a matching line with the stored word. In a third setting snooping is switched off, so the stale-copy hazard can be shown next to its cure.

Each core has a load/store port with a valid/ready handshake. A request finishes on the clock edge where valid and ready are both high. Read data comes back one cycle later with its own strobe. Read hits are served locally. Read misses and all stores need the bus. A round-robin arbiter grants the bus to one core per cycle. The memory sits outside the block: it is driven with an address, a write enable and write data, and it answers reads combinationally in the same cycle.

Top module: `coh_fabric`

## Requirements
- R1: After reset no cache line is valid. No read response is pending, and the bus is idle, so the first read of any address takes the bus.
- R2: A read that hits in the requesting core's cache gets ready with no bus grant. Its data appears with the read strobe in the next cycle.
- R3: A read miss is served only in a cycle where the requester holds the bus. It returns the memory word at that address and installs that word in the requester's cache.
- R4: Every store drives the memory write enable, with its own address and data, in the cycle it is granted.
- R5: At most one core holds the bus per cycle, and only a core that needs it. Grants rotate round-robin, starting at the core after the last one granted (core 0 first after reset). So a waiting core sees at most three grants go to others.
- R6: In invalidate mode, a store drops the matching line in every other cache. Their next read of that address misses and returns the stored word.
- R7: In update mode, a store overwrites the matching line in every other cache that holds it. Their next read hits and returns the stored word without the bus.
- R8: The broadcast flag marks a store that other caches must act on. It is set on every store in update mode. In invalidate mode it is set only when at least one other cache holds a valid copy. It is never set with snooping off.
- R9: With snooping off, other caches keep their copies across a store, so a later read hit there returns the old word.
- R10: The storing core installs or refreshes its own line with the stored word and never invalidates itself. Its next read of that address hits.
- R11: In invalidate and update modes, every read returns the word of the latest store to that address, ordered by bus grant. A read that hits in the same cycle as a store to the same address is ordered before that store.
- R12: The mode is decoded as follows: 2'b00 turns snooping off, 2'b01 selects invalidate, and 2'b10 or 2'b11 select update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Snooping policy select (R12) |
| core_valid | input | 4 | Per-core request valid |
| core_write | input | 4 | Per-core request is a store |
| core_addr | input | 4x6 | Per-core word address |
| core_wdata | input | 4x32 | Per-core store data |
| core_ready | output | 4 | Request completes at this edge |
| core_rvalid | output | 4 | Read data strobe, one cycle after a read completes |
| core_rdata | output | 4x32 | Read data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 6 | Memory address for the current bus cycle |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read word, combinational on mem_addr |
| bus_busy | output | 1 | A bus transaction is granted this cycle |
| bus_owner | output | 2 | Index of the granted core |
| bus_bcast | output | 1 | Current store is broadcast to the other caches (R8) |

## Verification
The properties assume three things about the inputs. A core holds its request fields steady from the moment valid rises until ready. Memory returns the addressed word in the same cycle. The mode changes only while no request is outstanding. The bench drives every request through one task that keeps the fields fixed until the handshake and leaves a gap before the next request. Its memory model reads combinationally. It changes the mode only between requests, and it applies a reset when leaving the snooping-off phase, so that no stale copy carries into a coherent phase.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int CORES_DEF  = 4;
    localparam int ADDR_W_DEF = 6;
    localparam int DATA_W_DEF = 32;
    localparam int LINES_DEF  = 8;

    typedef enum logic [1:0] {
        POL_OFF = 2'b00,
        POL_INV = 2'b01,
        POL_UPD = 2'b10
    } policy_e;

    function automatic policy_e decode_policy(input logic [1:0] m);
        policy_e p;
        if (m[1])      p = POL_UPD;
        else if (m[0]) p = POL_INV;
        else           p = POL_OFF;
        return p;
    endfunction

endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] last_q;
    logic [IW-1:0] cand;
    logic          found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IW'((int'(last_q) + k) % N);
            if (!found && req[cand]) begin
                found        = 1'b1;
                gnt[cand]    = 1'b1;
                gnt_idx      = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        last_q <= IW'(N - 1);
        else if (found) last_q <= gnt_idx;
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R5
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    generate
        for (genvar i = 0; i < N; i++) begin : g_wait
            logic [IW:0] wait_q;
            always_ff @(posedge clk) begin
                if (rst || !req[i] || gnt[i]) wait_q <= '0;
                else if (|gnt)                wait_q <= wait_q + 1'b1;
            end
            // R5
            rr_bound_chk: assert property (@(posedge clk) disable iff (rst)
                int'(wait_q) < N);
        end
    endgenerate

endmodule

// File: rtl/coh_cache.sv
module coh_cache import coh_pkg::*; #(
    parameter int AW    = ADDR_W_DEF,
    parameter int DW    = DATA_W_DEF,
    parameter int LINES = LINES_DEF,
    localparam int IDXW = $clog2(LINES),
    localparam int TAGW = AW - IDXW
) (
    input  logic          clk,
    input  logic          rst,
    input  policy_e       policy,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          gnt,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          need_bus,
    output logic          snoop_hit,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);

    typedef struct packed {
        logic            valid;
        logic [TAGW-1:0] tag;
        logic [DW-1:0]   data;
    } line_t;

    line_t lines [LINES];

    logic [IDXW-1:0] r_idx, b_idx;
    logic [TAGW-1:0] r_tag, b_tag;
    logic            r_hit;
    logic            snoop_write;

    assign r_idx = req_addr[IDXW-1:0];
    assign r_tag = req_addr[AW-1:IDXW];
    assign b_idx = bus_addr[IDXW-1:0];
    assign b_tag = bus_addr[AW-1:IDXW];

    assign r_hit     = lines[r_idx].valid && (lines[r_idx].tag == r_tag);
    assign snoop_hit = lines[b_idx].valid && (lines[b_idx].tag == b_tag);

    assign need_bus  = req_valid && (req_write || !r_hit);
    assign req_ready = req_valid && ((!req_write && r_hit) || gnt);

    assign snoop_write = bus_valid && bus_write && !gnt && snoop_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            for (int i = 0; i < LINES; i++) lines[i].valid <= 1'b0;
        end else begin
            rsp_valid <= req_ready && !req_write;
            if (req_ready && !req_write)
                rsp_data <= r_hit ? lines[r_idx].data : mem_rdata;
            if (gnt) begin
                lines[r_idx].valid <= 1'b1;
                lines[r_idx].tag   <= r_tag;
                lines[r_idx].data  <= req_write ? req_wdata : mem_rdata;
            end else if (snoop_write) begin
                case (policy)
                    POL_INV: lines[b_idx].valid <= 1'b0;
                    POL_UPD: lines[b_idx].data  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R2
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && r_hit) |-> !gnt);

    // R6
    inv_drops_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (snoop_write && policy == POL_INV) |=> !lines[$past(b_idx)].valid);

    // R7
    upd_copies_word_chk: assert property (@(posedge clk) disable iff (rst)
        (snoop_write && policy == POL_UPD) |=>
            (lines[$past(b_idx)].valid && lines[$past(b_idx)].data == $past(bus_wdata)));

    // R9
    off_keeps_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (snoop_write && policy == POL_OFF) |=>
            (lines[$past(b_idx)].valid && lines[$past(b_idx)].data == $past(lines[b_idx].data)));

    // R10
    own_store_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt && req_valid && req_write) |=>
            (lines[$past(r_idx)].valid && lines[$past(r_idx)].data == $past(req_wdata)));

endmodule

// File: rtl/coh_fabric.sv
module coh_fabric import coh_pkg::*; #(
    parameter int NUM_CORES = CORES_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int LINES     = LINES_DEF,
    localparam int OWN_W    = $clog2(NUM_CORES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [1:0]                       mode,
    input  logic [NUM_CORES-1:0]             core_valid,
    input  logic [NUM_CORES-1:0]             core_write,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] core_addr,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] core_wdata,
    output logic [NUM_CORES-1:0]             core_ready,
    output logic [NUM_CORES-1:0]             core_rvalid,
    output logic [NUM_CORES-1:0][DATA_W-1:0] core_rdata,
    output logic                             mem_we,
    output logic [ADDR_W-1:0]                mem_addr,
    output logic [DATA_W-1:0]                mem_wdata,
    input  logic [DATA_W-1:0]                mem_rdata,
    output logic                             bus_busy,
    output logic [OWN_W-1:0]                 bus_owner,
    output logic                             bus_bcast
);

    policy_e                policy;
    logic [NUM_CORES-1:0]   need, gnt, snoop_hit;
    logic [OWN_W-1:0]       gnt_idx;
    logic                   bus_write;
    logic [ADDR_W-1:0]      bus_addr;
    logic [DATA_W-1:0]      bus_wdata;
    logic                   others_hold;

    assign policy = decode_policy(mode);

    coh_rr_arb #(.N(NUM_CORES)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (need),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    assign bus_busy    = |gnt;
    assign bus_owner   = gnt_idx;
    assign bus_write   = bus_busy && core_write[gnt_idx];
    assign bus_addr    = core_addr[gnt_idx];
    assign bus_wdata   = core_wdata[gnt_idx];
    assign others_hold = |(snoop_hit & ~gnt);

    assign bus_bcast = bus_write &&
                       ((policy == POL_UPD) || (policy == POL_INV && others_hold));

    assign mem_we    = bus_write;
    assign mem_addr  = bus_addr;
    assign mem_wdata = bus_wdata;

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            coh_cache #(.AW(ADDR_W), .DW(DATA_W), .LINES(LINES)) u_cache (
                .clk       (clk),
                .rst       (rst),
                .policy    (policy),
                .req_valid (core_valid[c]),
                .req_write (core_write[c]),
                .req_addr  (core_addr[c]),
                .req_wdata (core_wdata[c]),
                .gnt       (gnt[c]),
                .bus_valid (bus_busy),
                .bus_write (bus_write),
                .bus_addr  (bus_addr),
                .bus_wdata (bus_wdata),
                .mem_rdata (mem_rdata),
                .need_bus  (need[c]),
                .snoop_hit (snoop_hit[c]),
                .req_ready (core_ready[c]),
                .rsp_valid (core_rvalid[c]),
                .rsp_data  (core_rdata[c])
            );

            // R4
            store_reaches_mem_chk: assert property (@(posedge clk) disable iff (rst)
                (core_valid[c] && core_write[c] && core_ready[c]) |->
                    (mem_we && mem_addr == core_addr[c] && mem_wdata == core_wdata[c]));

            // R3
            rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
                core_rvalid[c] |-> $past(core_valid[c] && core_ready[c] && !core_write[c]));
        end
    endgenerate

    // R8
    no_bcast_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> !bus_bcast);

    // R8
    bcast_only_on_store_chk: assert property (@(posedge clk) disable iff (rst)
        bus_bcast |-> mem_we);

endmodule

// File: tb/sim_coh_fabric.sv
module sim_coh_fabric;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [NC-1:0] c_valid = '0;
    logic [NC-1:0] c_write = '0;
    logic [NC-1:0][AW-1:0] c_addr = '0;
    logic [NC-1:0][DW-1:0] c_wdata = '0;
    logic [NC-1:0] core_ready, core_rvalid;
    logic [NC-1:0][DW-1:0] core_rdata;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic bus_busy, bus_bcast;
    logic [1:0] bus_owner;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];
    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 32'hA000_0000 + i;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    coh_fabric u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .core_valid(c_valid), .core_write(c_write), .core_addr(c_addr), .core_wdata(c_wdata),
        .core_ready(core_ready), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bus_busy(bus_busy), .bus_owner(bus_owner), .bus_bcast(bus_bcast)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        c_valid = '0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 32'hA000_0000 + i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One request: hold fields until ready, return response and bus observations.
    task automatic do_op(input int c, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd,
                         output logic [DW-1:0] ex, output bit used, output bit bc,
                         output int when, output bit rv);
        @(negedge clk);
        c_valid[c] = 1'b1;
        c_write[c] = we;
        c_addr[c]  = a;
        c_wdata[c] = d;
        #1;
        while (!core_ready[c]) begin
            @(negedge clk);
            #1;
        end
        used = bus_busy && (int'(bus_owner) == c);
        bc   = bus_bcast;
        ex   = ref_mem[a];
        when = cyc;
        @(posedge clk);
        if (we) ref_mem[a] = d;
        @(negedge clk);
        c_valid[c] = 1'b0;
        rd = core_rdata[c];
        rv = core_rvalid[c];
    endtask

    task automatic rand_core(input int c, input int n);
        logic [DW-1:0] rd, ex;
        bit used, bc, rv;
        int when;
        for (int k = 0; k < n; k++) begin
            bit we;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            we = ($urandom % 10) < 4;
            a  = AW'($urandom % 16);
            d  = $urandom;
            do_op(c, we, a, d, rd, ex, used, bc, when, rv);
            if (!we) begin
                check(rv, "R11 rvalid", {31'd0, rv}, 32'd1);
                check(rd == ex, "R11 coherent read", rd, ex);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] rd, ex;
        bit used, bc, rv;
        int when;
        int t [NC];
        logic [DW-1:0] rr_rd [NC];
        logic [DW-1:0] rr_ex [NC];
        bit rr_u [NC];
        bit rr_b [NC];
        bit rr_v [NC];

        void'($urandom(32'd20240517));

        // ---------- snooping off ----------
        mode = 2'b00;
        apply_reset();
        #1;
        check(core_rvalid == '0, "R1 no response after reset", {28'd0, core_rvalid}, 32'd0);
        check(!bus_busy && !mem_we, "R1 bus idle after reset", {31'd0, bus_busy}, 32'd0);

        do_op(0, 0, 6'd5, 0, rd, ex, used, bc, when, rv);
        check(used, "R1 first read takes bus", {31'd0, used}, 32'd1);
        check(rd == 32'hA000_0005 && rv, "R3 miss returns memory word", rd, 32'hA000_0005);
        do_op(0, 0, 6'd5, 0, rd, ex, used, bc, when, rv);
        check(!used, "R2 read hit without bus", {31'd0, used}, 32'd0);
        check(rd == 32'hA000_0005 && rv, "R2 hit data", rd, 32'hA000_0005);
        do_op(1, 0, 6'd5, 0, rd, ex, used, bc, when, rv);
        do_op(0, 1, 6'd5, 32'h1111_1111, rd, ex, used, bc, when, rv);
        check(!bc, "R8 no broadcast with snooping off", {31'd0, bc}, 32'd0);
        check(mem[5] == 32'h1111_1111, "R4 store reaches memory", mem[5], 32'h1111_1111);
        do_op(1, 0, 6'd5, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'hA000_0005, "R9 stale copy kept with snooping off", rd, 32'hA000_0005);
        check(!used, "R9 stale read is a local hit", {31'd0, used}, 32'd0);
        do_op(0, 0, 6'd5, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'h1111_1111 && !used, "R10 writer hits own stored word", rd, 32'h1111_1111);

        // ---------- invalidate ----------
        mode = 2'b01;
        apply_reset();
        do_op(2, 1, 6'd9, 32'h2222_2222, rd, ex, used, bc, when, rv);
        check(!bc, "R8 invalidate store without sharers not broadcast", {31'd0, bc}, 32'd0);
        do_op(2, 0, 6'd9, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'h2222_2222 && !used, "R10 store allocates in writer", rd, 32'h2222_2222);
        do_op(3, 0, 6'd9, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'h2222_2222, "R3 miss sees written memory", rd, 32'h2222_2222);
        do_op(2, 1, 6'd9, 32'h3333_3333, rd, ex, used, bc, when, rv);
        check(bc, "R8 invalidate store with sharer broadcast", {31'd0, bc}, 32'd1);
        do_op(3, 0, 6'd9, 0, rd, ex, used, bc, when, rv);
        check(used, "R6 invalidated reader misses", {31'd0, used}, 32'd1);
        check(rd == 32'h3333_3333, "R6 reader gets new word", rd, 32'h3333_3333);
        do_op(2, 0, 6'd9, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'h3333_3333 && !used, "R10 writer not self-invalidated", rd, 32'h3333_3333);
        do_op(3, 0, 6'd17, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'hA000_0011 && used, "R3 conflicting tag evicts and refetches", rd, 32'hA000_0011);

        // ---------- update ----------
        mode = 2'b10;
        apply_reset();
        do_op(0, 1, 6'd12, 32'h4444_4444, rd, ex, used, bc, when, rv);
        check(bc, "R8 update store always broadcast", {31'd0, bc}, 32'd1);
        do_op(1, 0, 6'd12, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'h4444_4444, "R3 fill before update", rd, 32'h4444_4444);
        do_op(0, 1, 6'd12, 32'h5555_5555, rd, ex, used, bc, when, rv);
        do_op(1, 0, 6'd12, 0, rd, ex, used, bc, when, rv);
        check(!used, "R7 updated copy hits", {31'd0, used}, 32'd0);
        check(rd == 32'h5555_5555, "R7 updated copy word", rd, 32'h5555_5555);
        mode = 2'b11;
        do_op(0, 1, 6'd12, 32'h6666_6666, rd, ex, used, bc, when, rv);
        check(bc, "R12 mode 11 acts as update", {31'd0, bc}, 32'd1);
        do_op(1, 0, 6'd12, 0, rd, ex, used, bc, when, rv);
        check(rd == 32'h6666_6666 && !used, "R12 mode 11 updates copies", rd, 32'h6666_6666);

        // round robin: last grant to core 1, so order is 2,3,0,1
        do_op(1, 1, 6'd20, 32'h7777_0000, rd, ex, used, bc, when, rv);
        fork
            do_op(0, 1, 6'd24, 32'h0, rr_rd[0], rr_ex[0], rr_u[0], rr_b[0], t[0], rr_v[0]);
            do_op(1, 1, 6'd25, 32'h1, rr_rd[1], rr_ex[1], rr_u[1], rr_b[1], t[1], rr_v[1]);
            do_op(2, 1, 6'd26, 32'h2, rr_rd[2], rr_ex[2], rr_u[2], rr_b[2], t[2], rr_v[2]);
            do_op(3, 1, 6'd27, 32'h3, rr_rd[3], rr_ex[3], rr_u[3], rr_b[3], t[3], rr_v[3]);
        join
        check(t[3] == t[2] + 1, "R5 core 3 after core 2", t[3], t[2] + 1);
        check(t[0] == t[3] + 1, "R5 core 0 after core 3", t[0], t[3] + 1);
        check(t[1] == t[0] + 1, "R5 core 1 after core 0", t[1], t[0] + 1);

        // ---------- random coherence ----------
        for (int ph = 0; ph < 2; ph++) begin
            mode = (ph == 0) ? 2'b01 : 2'b10;
            apply_reset();
            fork
                rand_core(0, 150);
                rand_core(1, 150);
                rand_core(2, 150);
                rand_core(3, 150);
            join
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule